// File: doc/BRIEF.md
# LIN Master Receive-Frame Sequencer

This block is the master side of a LIN bus for frames in which the master asks a slave for data. Software builds one request by writing four command bytes, one after another, into a single write-only command register. Each byte sits on the top byte lane of the 32-bit write word. The four bytes are the protected identifier, the number of response bytes, a control byte and the low part of the timeout. The block does nothing on the bus until the fourth byte arrives. It then sends the header: a long dominant break, a delimiter, the 0x55 sync byte, and the protected identifier exactly as it was written.

Once the header is out, the block listens on the receive line. It delivers each response data byte on a one-cycle strobe. When checksum checking is on, it also takes one more byte and compares it with the classic LIN checksum of the data bytes. A bit-time timeout, set by a 12-bit value split across two command bytes, ends a response that arrives too slowly. Sticky status flags report the outcome: transmit-ready, frame done, checksum error and timeout. Software clears each flag by writing a one to its bit through the status register. All bit timing comes from an external one-cycle baud tick.

Top module: `lin_rxhdr_master`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 takes one command byte from `wr_data[31:24]` and ignores the other lanes. The first byte is the protected identifier, the second is the response byte count, the third is the control byte and the fourth is the timeout low byte. No header starts before the fourth byte is written.
- R2: In the control byte, bit 7 enables checksum checking and bits 3:0 are timeout bits 11:8. Bit 4 selects the direction and must be 0 for a receive frame. If it is 1, the fourth write discards the command: no header is sent and the write count returns to zero.
- R3: The header, timed one baud-tick period per bit, is sent in this order:
  - 13 dominant (0) bits;
  - 1 recessive delimiter bit;
  - the byte 0x55;
  - the identifier byte, unchanged.

  Each byte is framed with a 0 start bit and a 1 stop bit and sent LSB first. `lin_tx` is 1 at all other times.
- R4: `txrdy` is 1 after reset. It is set after each accepted command byte that does not launch a header, after a discarded command, and when a frame ends. It clears when a header launches, and it clears when the status register (`wr_sel`=1) is written with bit 0 set.
- R5: Command writes made while a header or response is in progress are ignored, and the write count is zero again after every completed or timed-out frame.
- R6: Response bytes are received as a start bit, 8 data bits LSB first and a stop bit, each sampled on a baud tick. Each of the first N bytes, where N is the count byte, appears on `rx_data` with `rx_valid` high for one cycle. A byte whose stop bit is 0 is dropped.
- R7: With checksum checking on, one more byte follows the data. It must equal the bitwise inverse of the 8-bit sum with end-around carry of the data bytes; a mismatch sets `cksum_err`. This byte is not shown on `rx_valid`.
- R8: `frame_done` is set when all expected bytes (N, plus one when checksum checking is on) have been received, and the block returns to accepting commands.
- R9: The timeout T is {control[3:0], fourth byte}. It counts baud ticks after the header's last bit tick. On the T-th tick, if the response is still incomplete, `rsp_timeout` is set, `frame_done` is not set, and the block returns to accepting commands.
- R10: `frame_done`, `cksum_err` and `rsp_timeout` stay set until a status write has a 1 in bit 1, bit 2 or bit 3 respectively. Only the flags whose bits are written with 1 are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = command register, 1 = status (write-one-to-clear) |
| wr_data | input | 32 | Write data; command byte on bits 31:24, status clear bits on 3:0 |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| lin_rx | input | 1 | Serial receive line |
| lin_tx | output | 1 | Serial transmit line |
| rx_data | output | 8 | Received response data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| txrdy | output | 1 | Next command byte may be written |
| frame_done | output | 1 | Response completed (sticky) |
| cksum_err | output | 1 | Checksum mismatch (sticky) |
| rsp_timeout | output | 1 | Response timed out (sticky) |

## Verification
Each header is decoded bit by bit against a sequence the bench builds itself, using several identifier values with the unused lanes filled with noise. This shows whether the byte lane, the field order and the LSB-first framing are right. The responses cover three cases:
- data with a correct checksum, where the data bytes sum past 255 so that the end-around carry matters;
- data with a wrong checksum;
- data with checking off.

Together these separate the checksum arithmetic from the plain byte count. The remaining patterns are a command with the direction bit set, a stray write during a header, and a request that gets no answer. The last one is watched tick by tick, so an off-by-one in the timeout or in the write counter shows up.

// File: rtl/lin_rxhdr_pkg.sv
package lin_rxhdr_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_HDR     = 2'd1,
    ST_RESP    = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  pid;
    logic [7:0]  nbytes;
    logic        chk_en;
    logic [11:0] tmo;
  } frame_cmd_t;

  // control byte fields
  localparam int CTL_CHK_BIT = 7;
  localparam int CTL_DIR_BIT = 4;

  // status write-one-to-clear bit positions
  localparam int STB_RDY  = 0;
  localparam int STB_DONE = 1;
  localparam int STB_CKE  = 2;
  localparam int STB_TMO  = 3;

  // header bit at position idx: break, delimiter, sync frame, identifier frame
  function automatic logic hdr_bit(input int idx, input int brk, input logic [7:0] pid);
    logic [9:0] fr;
    int k;
    if (idx < brk) return 1'b0;
    if (idx == brk) return 1'b1;
    k = idx - brk - 1;
    if (k < 10) begin
      fr = {1'b1, 8'h55, 1'b0};
    end else begin
      fr = {1'b1, pid, 1'b0};
      k  = k - 10;
    end
    return fr[k[3:0]];
  endfunction

  // classic checksum step: 8-bit add with end-around carry
  function automatic logic [7:0] chk_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_cmd_collect.sv
module lin_cmd_collect
  import lin_rxhdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        wr_cmd,
  input  logic [7:0]  wr_byte,
  output frame_cmd_t  cmd,
  output logic [1:0]  wcnt,
  output logic        launch,
  output logic        discard,
  output logic        byte_taken
);

  logic [7:0] pid_q, cnt_q, ctl_q, tlo_q;
  logic       take;
  logic       unused_ctl;

  assign take       = accept & wr_cmd;
  assign launch     = take & (wcnt == 2'd3) & ~ctl_q[CTL_DIR_BIT];
  assign discard    = take & (wcnt == 2'd3) &  ctl_q[CTL_DIR_BIT];
  assign byte_taken = take & (wcnt != 2'd3);
  assign unused_ctl = ^ctl_q[6:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt  <= 2'd0;
      pid_q <= 8'd0;
      cnt_q <= 8'd0;
      ctl_q <= 8'd0;
      tlo_q <= 8'd0;
    end else if (take) begin
      unique case (wcnt)
        2'd0: pid_q <= wr_byte;
        2'd1: cnt_q <= wr_byte;
        2'd2: ctl_q <= wr_byte;
        default: tlo_q <= wr_byte;
      endcase
      wcnt <= wcnt + 2'd1;
    end
  end

  // timeout low byte is taken from the launching write itself
  always_comb begin
    cmd.pid    = pid_q;
    cmd.nbytes = cnt_q;
    cmd.chk_en = ctl_q[CTL_CHK_BIT];
    cmd.tmo    = {ctl_q[3:0], (take && wcnt == 2'd3) ? wr_byte : tlo_q};
  end

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_rxhdr_pkg::*;
#(
  parameter int BREAK_BITS = 13,
  localparam int HDR_BITS = BREAK_BITS + 21,
  localparam int IDX_W    = $clog2(HDR_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [7:0]       pid,
  output logic             tx,
  output logic             busy,
  output logic             act,
  output logic [IDX_W-1:0] idx,
  output logic             done_evt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(HDR_BITS - 1);

  logic pend;

  assign busy     = pend | act;
  assign done_evt = act & tick & (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
      idx  <= '0;
      tx   <= 1'b1;
    end else begin
      if (start) pend <= 1'b1;
      if (tick) begin
        if (pend) begin
          pend <= 1'b0;
          act  <= 1'b1;
          idx  <= '0;
          tx   <= hdr_bit(0, BREAK_BITS, pid);
        end else if (act) begin
          if (idx == LAST) begin
            act <= 1'b0;
            tx  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            tx  <= hdr_bit(int'(idx) + 1, BREAK_BITS, pid);
          end
        end
      end
    end
  end

endmodule

// File: rtl/lin_rx_byte.sv
module lin_rx_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rx,
  output logic       valid,
  output logic [7:0] data
);

  logic       busy;
  logic [3:0] bitn;
  logic [7:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      bitn  <= 4'd0;
      sh    <= 8'd0;
      valid <= 1'b0;
      data  <= 8'd0;
    end else begin
      valid <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        bitn <= 4'd0;
      end else if (tick) begin
        if (!busy) begin
          if (!rx) begin
            busy <= 1'b1;
            bitn <= 4'd0;
          end
        end else if (bitn < 4'd8) begin
          sh   <= {rx, sh[7:1]};
          bitn <= bitn + 4'd1;
        end else begin
          busy <= 1'b0;
          if (rx) begin
            valid <= 1'b1;
            data  <= sh;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lin_resp_ctrl.sv
module lin_resp_ctrl
  import lin_rxhdr_pkg::*;
#(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             tick,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [7:0]       nbytes,
  input  logic             chk_en,
  input  logic [TMO_W-1:0] tmo,
  output logic             data_evt,
  output logic             err_evt,
  output logic             done_evt,
  output logic             tmo_evt,
  output logic [8:0]       got,
  output logic [8:0]       total
);

  logic [7:0]       sum;
  logic [TMO_W-1:0] tcnt;
  logic [8:0]       nb9;
  logic             last_byte;
  logic             tmo_hit;

  assign nb9       = {1'b0, nbytes};
  assign total     = nb9 + {8'd0, chk_en};
  assign data_evt  = active & byte_valid & (got < nb9);
  assign err_evt   = active & byte_valid & ~(got < nb9) & (byte_data != ~sum);
  assign last_byte = active & byte_valid & ((got + 9'd1) == total);
  assign done_evt  = last_byte | (active & (total == 9'd0));
  assign tmo_hit   = ({1'b0, tcnt} + (TMO_W+1)'(1)) == {1'b0, tmo};
  assign tmo_evt   = active & ~done_evt & tick & (tmo != '0) & tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got  <= 9'd0;
      sum  <= 8'd0;
      tcnt <= '0;
    end else if (start) begin
      got  <= 9'd0;
      sum  <= 8'd0;
      tcnt <= '0;
    end else if (active) begin
      if (byte_valid) got <= got + 9'd1;
      if (data_evt)   sum <= chk_add(sum, byte_data);
      if (tick)       tcnt <= tcnt + 1'b1;
    end
  end

endmodule

// File: rtl/lin_rxhdr_master.sv
module lin_rxhdr_master
  import lin_rxhdr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BREAK_BITS  = 13,
  parameter int SYNC_STAGES = 2,
  localparam int LANE_LSB = DATA_W - 8,
  localparam int HDR_BITS = BREAK_BITS + 21,
  localparam int IDX_W    = $clog2(HDR_BITS + 1),
  localparam int TMO_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  input  logic              lin_rx,
  output logic              lin_tx,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              txrdy,
  output logic              frame_done,
  output logic              cksum_err,
  output logic              rsp_timeout
);

  seq_state_e       state;
  frame_cmd_t       cmd;
  logic [1:0]       wcnt;
  logic             cmd_wr, stat_wr;
  logic             launch, discard, byte_taken;
  logic             hdr_busy, hdr_act, hdr_done;
  logic [IDX_W-1:0] hdr_idx;
  logic             hdr_in_break;
  logic             rx_s;
  logic             byte_valid;
  logic [7:0]       byte_data;
  logic             data_evt, err_evt, done_evt, tmo_evt;
  logic [8:0]       got, total;
  logic             frame_end;
  logic             unused_wr;

  assign cmd_wr       = wr_en & ~wr_sel;
  assign stat_wr      = wr_en &  wr_sel;
  assign frame_end    = done_evt | tmo_evt;
  assign hdr_in_break = hdr_act & (hdr_idx < IDX_W'(BREAK_BITS));
  assign unused_wr    = ^wr_data[LANE_LSB-1:4] ^ hdr_busy;

  // receive line synchronizer
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign rx_s = lin_rx;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] stg;
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b1;
          else        stg[i] <= (i == 0) ? lin_rx : stg[(i == 0) ? 0 : i-1];
        end
      end
      assign rx_s = stg[SYNC_STAGES-1];
    end
  endgenerate

  lin_cmd_collect u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (state == ST_COLLECT),
    .wr_cmd     (cmd_wr),
    .wr_byte    (wr_data[DATA_W-1:LANE_LSB]),
    .cmd        (cmd),
    .wcnt       (wcnt),
    .launch     (launch),
    .discard    (discard),
    .byte_taken (byte_taken)
  );

  lin_hdr_tx #(.BREAK_BITS(BREAK_BITS)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .tick     (baud_tick),
    .pid      (cmd.pid),
    .tx       (lin_tx),
    .busy     (hdr_busy),
    .act      (hdr_act),
    .idx      (hdr_idx),
    .done_evt (hdr_done)
  );

  lin_rx_byte u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == ST_RESP),
    .tick  (baud_tick),
    .rx    (rx_s),
    .valid (byte_valid),
    .data  (byte_data)
  );

  lin_resp_ctrl #(.TMO_W(TMO_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (hdr_done),
    .active     (state == ST_RESP),
    .tick       (baud_tick),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .nbytes     (cmd.nbytes),
    .chk_en     (cmd.chk_en),
    .tmo        (cmd.tmo),
    .data_evt   (data_evt),
    .err_evt    (err_evt),
    .done_evt   (done_evt),
    .tmo_evt    (tmo_evt),
    .got        (got),
    .total      (total)
  );

  assign rx_valid = data_evt;
  assign rx_data  = byte_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_COLLECT;
    end else begin
      unique case (state)
        ST_COLLECT: if (launch)    state <= ST_HDR;
        ST_HDR:     if (hdr_done)  state <= ST_RESP;
        ST_RESP:    if (frame_end) state <= ST_COLLECT;
        default:                   state <= ST_COLLECT;
      endcase
    end
  end

  // sticky flags: hardware set wins over write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy       <= 1'b1;
      frame_done  <= 1'b0;
      cksum_err   <= 1'b0;
      rsp_timeout <= 1'b0;
    end else begin
      if (byte_taken | discard | frame_end)            txrdy <= 1'b1;
      else if (launch | (stat_wr & wr_data[STB_RDY]))  txrdy <= 1'b0;

      if (done_evt)                          frame_done <= 1'b1;
      else if (stat_wr & wr_data[STB_DONE])  frame_done <= 1'b0;

      if (err_evt)                           cksum_err <= 1'b1;
      else if (stat_wr & wr_data[STB_CKE])   cksum_err <= 1'b0;

      if (tmo_evt)                           rsp_timeout <= 1'b1;
      else if (stat_wr & wr_data[STB_TMO])   rsp_timeout <= 1'b0;
    end
  end

endmodule

// File: rtl/lin_rxhdr_master_chk.sv
module lin_rxhdr_master_chk
  import lin_rxhdr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input seq_state_e state,
  input logic       lin_tx,
  input logic       hdr_in_break,
  input logic       cmd_wr,
  input logic [1:0] wcnt,
  input logic       launch,
  input logic       txrdy,
  input logic       done_evt,
  input logic       tmo_evt,
  input logic [8:0] got,
  input logic [8:0] total,
  input logic       rx_valid
);

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COLLECT) |-> lin_tx); // R3

  AST_BREAK_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_in_break |-> !lin_tx); // R3

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_COLLECT && cmd_wr) |=> $stable(wcnt)); // R5

  AST_COUNT_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESP && (done_evt || tmo_evt)) |=> (wcnt == 2'd0)); // R5

  AST_LAUNCH_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !txrdy); // R4

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && tmo_evt)); // R9

  AST_TMO_INCOMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> (got < total)); // R9

  AST_RXVALID_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (state == ST_RESP)); // R6

endmodule

bind lin_rxhdr_master lin_rxhdr_master_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (state),
  .lin_tx       (lin_tx),
  .hdr_in_break (hdr_in_break),
  .cmd_wr       (cmd_wr),
  .wcnt         (wcnt),
  .launch       (launch),
  .txrdy        (txrdy),
  .done_evt     (done_evt),
  .tmo_evt      (tmo_evt),
  .got          (got),
  .total        (total),
  .rx_valid     (rx_valid)
);

// File: tb/lin_rxhdr_master_tb.sv
`timescale 1ns/1ps
module lin_rxhdr_master_tb;

  localparam int BAUD_DIV = 8;
  localparam int BRK      = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic        baud_tick = 1'b0;
  logic        lin_rx = 1'b1;
  logic        lin_tx;
  logic [7:0]  rx_data;
  logic        rx_valid;
  logic        txrdy, frame_done, cksum_err, rsp_timeout;

  int checks = 0;
  int errors = 0;
  int hdr_seen = 0;
  int rx_seen = 0;
  bit finished = 1'b0;

  bit         exp_hdr[$];
  logic [7:0] exp_rx[$];

  always #2 clk = ~clk;

  lin_rxhdr_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .baud_tick(baud_tick), .lin_rx(lin_rx), .lin_tx(lin_tx), .rx_data(rx_data),
    .rx_valid(rx_valid), .txrdy(txrdy), .frame_done(frame_done),
    .cksum_err(cksum_err), .rsp_timeout(rsp_timeout)
  );

  int tick_div = 0;
  always @(negedge clk) begin
    tick_div  <= (tick_div == BAUD_DIV-1) ? 0 : tick_div + 1;
    baud_tick <= (tick_div == BAUD_DIV-1);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr_cmd(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = {b, 24'hA5C35A};
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
  endtask

  task automatic wr_stat(input logic [3:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = {28'h0, m};
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 32'd0;
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    @(negedge clk);
  endtask

  // expected header built from the frame rules (R3)
  task automatic push_header(input logic [7:0] pid);
    logic [7:0] fr [2];
    fr[0] = 8'h55; fr[1] = pid;
    for (int i = 0; i < BRK; i++) exp_hdr.push_back(1'b0);
    exp_hdr.push_back(1'b1);
    for (int f = 0; f < 2; f++) begin
      exp_hdr.push_back(1'b0);
      for (int b = 0; b < 8; b++) exp_hdr.push_back(fr[f][b]);
      exp_hdr.push_back(1'b1);
    end
  endtask

  task automatic start_frame(input logic [7:0] pid, input logic [7:0] n,
                             input logic [7:0] ctl, input logic [7:0] tlo);
    wr_cmd(pid);
    wr_cmd(n);
    wr_cmd(ctl);
    if (!ctl[4]) push_header(pid);
    wr_cmd(tlo);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      wait_tick();
      lin_rx = fr[i];
    end
    wait_tick();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] own_cks(input logic [7:0] d [$]);
    int s = 0;
    foreach (d[i]) begin
      s = s + d[i];
      if (s > 255) s = s - 255;
    end
    return ~(8'(s));
  endfunction

  // header monitor
  initial begin
    bit prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !lin_tx) begin
        if (exp_hdr.size() < BRK + 21) begin
          check(1'b0, "R2 R3 unexpected header", 0, 1);
        end else begin
          for (int i = 0; i < BRK + 21; i++) begin
            bit e;
            repeat ((i == 0) ? BAUD_DIV/2 : BAUD_DIV) @(negedge clk);
            e = exp_hdr.pop_front();
            check(lin_tx == e, "R3 header bit", lin_tx, e);
          end
          repeat (BAUD_DIV) @(negedge clk);
          check(lin_tx == 1'b1, "R3 line high after header", lin_tx, 1);
          hdr_seen++;
        end
      end
      prev = lin_tx;
    end
  end

  // response data monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rx_valid) begin
        rx_seen++;
        if (exp_rx.size() == 0) begin
          check(1'b0, "R6 unexpected rx byte", rx_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R6 rx data", rx_data, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d [$];
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(txrdy == 1'b1, "R4 txrdy after reset", txrdy, 1);
    check(frame_done == 1'b0, "R8 done after reset", frame_done, 0);
    check(cksum_err == 1'b0, "R7 cksum_err after reset", cksum_err, 0);
    check(rsp_timeout == 1'b0, "R9 timeout after reset", rsp_timeout, 0);
    check(lin_tx == 1'b1, "R3 line idle after reset", lin_tx, 1);

    // frame A: checksum on, data sum wraps
    wr_stat(4'b0001);
    check(txrdy == 1'b0, "R4 txrdy W1C", txrdy, 0);
    wr_cmd(8'h92);
    check(txrdy == 1'b1, "R4 txrdy after byte", txrdy, 1);
    wr_cmd(8'd3);
    wr_cmd(8'h81);
    repeat (20) wait_tick();
    check(hdr_seen == 0 && lin_tx == 1'b1, "R1 no header before 4th byte", hdr_seen, 0);
    push_header(8'h92);
    wr_cmd(8'h90);
    check(txrdy == 1'b0, "R4 txrdy cleared at launch", txrdy, 0);
    repeat (5) wait_tick();
    wr_cmd(8'hE7);
    check(txrdy == 1'b0, "R5 write during header ignored", txrdy, 0);
    wait (hdr_seen == 1);
    d = '{8'h4A, 8'h13, 8'hF0};
    foreach (d[i]) exp_rx.push_back(d[i]);
    base = rx_seen;
    foreach (d[i]) send_byte(d[i]);
    send_byte(own_cks(d));
    check(frame_done == 1'b1, "R8 done after full response", frame_done, 1);
    check(cksum_err == 1'b0, "R7 good checksum", cksum_err, 0);
    check(rx_seen - base == 3, "R7 checksum byte not strobed", rx_seen - base, 3);
    check(txrdy == 1'b1, "R4 txrdy at frame end", txrdy, 1);

    // R10 partial clear
    wr_stat(4'b0010);
    check(frame_done == 1'b0 && txrdy == 1'b1, "R10 only done cleared",
          {frame_done, txrdy}, 2'b01);

    // frame B: wrong checksum, end-around carry case
    start_frame(8'h2B, 8'd2, 8'h81, 8'h90);
    wait (hdr_seen == 2);
    d = '{8'hFF, 8'h01};
    foreach (d[i]) exp_rx.push_back(d[i]);
    foreach (d[i]) send_byte(d[i]);
    check(own_cks(d) == 8'hFE, "R7 bench checksum", own_cks(d), 8'hFE);
    send_byte(8'h55);
    check(cksum_err == 1'b1, "R7 bad checksum flagged", cksum_err, 1);
    check(frame_done == 1'b1, "R8 done with bad checksum", frame_done, 1);
    wr_stat(4'b0110);
    check(cksum_err == 1'b0 && frame_done == 1'b0, "R10 clear two flags",
          {cksum_err, frame_done}, 0);

    // frame C: checksum off
    start_frame(8'hC1, 8'd2, 8'h01, 8'h90);
    wait (hdr_seen == 3);
    exp_rx.push_back(8'h00);
    exp_rx.push_back(8'h81);
    send_byte(8'h00);
    check(frame_done == 1'b0, "R8 not done after first byte", frame_done, 1'b0);
    send_byte(8'h81);
    check(frame_done == 1'b1 && cksum_err == 1'b0, "R8 done without checksum",
          {frame_done, cksum_err}, 2'b10);
    wr_stat(4'b0010);

    // direction bit set: discarded
    start_frame(8'h3C, 8'd2, 8'h10, 8'h40);
    check(txrdy == 1'b1, "R2 txrdy after discard", txrdy, 1);
    repeat (50) wait_tick();
    check(hdr_seen == 3 && lin_tx == 1'b1, "R2 no header for direction 1", hdr_seen, 3);
    check(frame_done == 1'b0, "R2 no frame for direction 1", frame_done, 0);

    // frame D: timeout with no answer
    start_frame(8'h64, 8'd2, 8'h00, 8'd25);
    wait (hdr_seen == 4);
    for (int k = 1; k <= 25; k++) begin
      wait_tick();
      if (k == 24) check(rsp_timeout == 1'b0, "R9 no timeout before T", rsp_timeout, 0);
      if (k == 25) check(rsp_timeout == 1'b1, "R9 timeout at T", rsp_timeout, 1);
    end
    check(frame_done == 1'b0, "R9 no done on timeout", frame_done, 0);
    check(txrdy == 1'b1, "R5 ready after timeout", txrdy, 1);
    wr_stat(4'b1000);
    check(rsp_timeout == 1'b0, "R10 timeout cleared", rsp_timeout, 0);

    // count reset after abort: next frame launches after exactly four writes
    start_frame(8'hA3, 8'd1, 8'h00, 8'h90);
    wait (hdr_seen == 5);
    exp_rx.push_back(8'h7E);
    send_byte(8'h7E);
    check(frame_done == 1'b1, "R5 frame after abort", frame_done, 1);
    check(exp_rx.size() == 0 && exp_hdr.size() == 0, "R6 scoreboard drained",
          exp_rx.size() + exp_hdr.size(), 0);

    summary();
  end

endmodule